// File: doc/BRIEF.md
# Dual-Read-Port Write-Through Data Cache

A level-one data cache that uses physical addresses and serves two independent loads in the same clock cycle. It is direct-mapped with 8 KiB of storage in 32-byte lines. Load lookups are combinational. A requester keeps its load valid until it sees a hit. A load that misses starts a line refill from the next level, and the next level returns the whole line in a single beat.

Each store is forwarded to the next level in the same cycle that it is presented. A store that hits also updates the enabled bytes of the cached line. Lines are therefore never dirty, and a store miss allocates nothing. The next level drives a back-invalidate when it evicts a line. The cache then drops any copy of that line, so its contents remain a subset of the next level.

Load and store addresses are word addresses (byte address shifted right by 3). Refill and invalidate addresses are line addresses (byte address shifted right by 5).

Top module: `dcache_dual_rd`

## Requirements
- R1: The cache holds 256 direct-mapped lines of 32 bytes.
  - A byte address splits into offset [4:0], index [12:5] and tag [31:13].
  - Bits [4:3] select one of four 64-bit words in the line.
  - Byte k of a refill line sits at bits [8k+7:8k], and word w is bits [64w+63:64w].
- R2: Both load ports can hit in the same cycle, including on the same line. Each port returns its own word combinationally in that cycle.
- R3: A valid store appears on the write-through outputs in the same cycle, with the same word address, byte enables and data, whether it hits or misses.
- R4: A store hit replaces only the bytes whose enable is set. Enable bit j covers data bits [8j+7:8j]. Loads see the new bytes from the next cycle.
- R5: A store miss does not allocate. It raises no refill request, and a later load to that line still misses.
- R6: A load miss while no refill is outstanding raises refill_req_o with the line address in the next cycle. The request and address are held until refill_valid_i. The line hits from the cycle after refill_valid_i.
- R7: When both ports miss in the same cycle, port 0's line is requested first. Port 1's line is requested once the first refill has completed.
- R8: A load to the line of an outstanding refill does not hit until that refill has completed.
- R9: A back-invalidate clears the cached line only when both tag and index match. A line with the same index but a different tag stays valid.
- R10: A back-invalidate for the line whose refill completes in the same cycle wins, and the line ends up invalid.
- R11: A store to the line whose refill completes in the same cycle is merged into the installed line.
- R12: After reset every line is invalid and no refill is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld0_valid_i | input | 1 | Load port 0 request |
| ld0_addr_i | input | 29 | Load port 0 word address |
| ld0_hit_o | output | 1 | Load port 0 hit |
| ld0_data_o | output | 64 | Load port 0 word |
| ld1_valid_i | input | 1 | Load port 1 request |
| ld1_addr_i | input | 29 | Load port 1 word address |
| ld1_hit_o | output | 1 | Load port 1 hit |
| ld1_data_o | output | 64 | Load port 1 word |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | 29 | Store word address |
| st_be_i | input | 8 | Store byte enables |
| st_data_i | input | 64 | Store data |
| wt_valid_o | output | 1 | Write-through request to next level |
| wt_addr_o | output | 29 | Write-through word address |
| wt_be_o | output | 8 | Write-through byte enables |
| wt_data_o | output | 64 | Write-through data |
| refill_req_o | output | 1 | Refill outstanding |
| refill_addr_o | output | 27 | Refill line address |
| refill_valid_i | input | 1 | Refill line delivered this cycle |
| refill_data_i | input | 256 | Refill line data |
| inval_valid_i | input | 1 | Back-invalidate from next level |
| inval_addr_i | input | 27 | Back-invalidate line address |

## Verification
Two cases place competing updates on the same line in the same cycle.

- **Refill with back-invalidate.** The bench drives a back-invalidate for a line in the exact cycle its refill is delivered. It then expects the held load to miss on the following cycle and a fresh refill request to appear for the same line.
- **Refill with store.** A store is presented to a line in its refill-delivery cycle. The bench judges this case by the word loaded afterwards, which must carry the store bytes over the refill bytes.

Both load ports are also driven together:
- on two hits, to check independent data;
- on two misses, to check refill order;
- on a line still being refilled, to check that the second port does not hit early.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int NUM_LD   = 2;
  localparam int ST_RD    = NUM_LD;
  localparam int RD_PORTS = NUM_LD + 1;

  typedef enum logic {
    RF_IDLE,
    RF_WAIT
  } rf_state_e;
endpackage

// File: rtl/dcache_array.sv
module dcache_array #(
  parameter int LINES  = 256,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 19,
  parameter int LINE_W = 256,
  parameter int NRD    = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0]    rd_idx_i,
  output logic [NRD-1:0]               rd_vld_o,
  output logic [NRD-1:0][TAG_W-1:0]    rd_tag_o,
  output logic [NRD-1:0][LINE_W-1:0]   rd_line_o,
  input  logic                         st_we_i,
  input  logic [IDX_W-1:0]             st_idx_i,
  input  logic [LINE_W-1:0]            st_line_i,
  input  logic                         fill_we_i,
  input  logic [IDX_W-1:0]             fill_idx_i,
  input  logic [TAG_W-1:0]             fill_tag_i,
  input  logic [LINE_W-1:0]            fill_line_i,
  input  logic                         inv_en_i,
  input  logic [IDX_W-1:0]             inv_idx_i,
  input  logic [TAG_W-1:0]             inv_tag_i
);
  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q;
  logic              inv_kill;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_vld_o[p]  = vld_q[rd_idx_i[p]];
    assign rd_tag_o[p]  = tag_q[rd_idx_i[p]];
    assign rd_line_o[p] = data_q[rd_idx_i[p]];
  end

  // invalidate targets the tag being installed when a fill lands on the same index
  always_comb begin
    if (fill_we_i && (fill_idx_i == inv_idx_i))
      inv_kill = inv_en_i && (fill_tag_i == inv_tag_i);
    else
      inv_kill = inv_en_i && vld_q[inv_idx_i] && (tag_q[inv_idx_i] == inv_tag_i);
  end

  always_ff @(posedge clk_i) begin
    if (st_we_i)   data_q[st_idx_i]   <= st_line_i;
    if (fill_we_i) data_q[fill_idx_i] <= fill_line_i;
    if (fill_we_i) tag_q[fill_idx_i]  <= fill_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (fill_we_i) vld_q[fill_idx_i] <= 1'b1;
      if (inv_kill)  vld_q[inv_idx_i]  <= 1'b0;
    end
  end
endmodule

// File: rtl/dcache_lookup.sv
module dcache_lookup #(
  parameter int TAG_W  = 19,
  parameter int LINE_W = 256,
  parameter int WORD_W = 64,
  parameter int WSEL_W = 2
) (
  input  logic              req_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic              blk_i,
  input  logic              arr_vld_i,
  input  logic [TAG_W-1:0]  arr_tag_i,
  input  logic [LINE_W-1:0] arr_line_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [WORD_W-1:0] data_o
);
  assign hit_o  = req_i && arr_vld_i && (arr_tag_i == tag_i) && !blk_i;
  assign miss_o = req_i && !hit_o;
  assign data_o = arr_line_i[wsel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/dcache_byte_merge.sv
module dcache_byte_merge #(
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 8,
  parameter int WSEL_W     = 2
) (
  input  logic [LINE_BYTES*8-1:0] base_i,
  input  logic                    en_i,
  input  logic [WSEL_W-1:0]       wsel_i,
  input  logic [WORD_BYTES-1:0]   be_i,
  input  logic [WORD_BYTES*8-1:0] data_i,
  output logic [LINE_BYTES*8-1:0] line_o
);
  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (en_i && (WSEL_W'(b / WORD_BYTES) == wsel_i) && be_i[b % WORD_BYTES])
        line_o[b*8 +: 8] = data_i[(b % WORD_BYTES)*8 +: 8];
      else
        line_o[b*8 +: 8] = base_i[b*8 +: 8];
    end
  end
endmodule

// File: rtl/dcache_refill_ctrl.sv
module dcache_refill_ctrl
  import dcache_pkg::*;
#(
  parameter int LA_W = 27
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_LD-1:0]            miss_i,
  input  logic [NUM_LD-1:0][LA_W-1:0]  miss_line_i,
  input  logic                         done_i,
  output logic                         busy_o,
  output logic [LA_W-1:0]              line_o,
  output logic                         fill_o
);
  rf_state_e       state_q;
  logic [LA_W-1:0] line_q;
  logic [LA_W-1:0] pick;

  // lowest port number wins
  always_comb begin
    pick = line_q;
    for (int p = NUM_LD - 1; p >= 0; p--)
      if (miss_i[p]) pick = miss_line_i[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
    end else begin
      case (state_q)
        RF_IDLE: if (|miss_i) begin
          state_q <= RF_WAIT;
          line_q  <= pick;
        end
        RF_WAIT: if (done_i) state_q <= RF_IDLE;
        default: state_q <= RF_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == RF_WAIT);
  assign line_o = line_q;
  assign fill_o = busy_o && done_i;
endmodule

// File: rtl/dcache_dual_rd.sv
module dcache_dual_rd
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 32,
  parameter int WORD_BYTES  = 8,
  localparam int LINES   = CACHE_BYTES / LINE_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int BSEL_W  = $clog2(WORD_BYTES),
  localparam int WSEL_W  = OFF_W - BSEL_W,
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int WA_W    = ADDR_W - BSEL_W,
  localparam int LA_W    = ADDR_W - OFF_W,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int WORD_W  = WORD_BYTES * 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ld0_valid_i,
  input  logic [WA_W-1:0]       ld0_addr_i,
  output logic                  ld0_hit_o,
  output logic [WORD_W-1:0]     ld0_data_o,
  input  logic                  ld1_valid_i,
  input  logic [WA_W-1:0]       ld1_addr_i,
  output logic                  ld1_hit_o,
  output logic [WORD_W-1:0]     ld1_data_o,
  input  logic                  st_valid_i,
  input  logic [WA_W-1:0]       st_addr_i,
  input  logic [WORD_BYTES-1:0] st_be_i,
  input  logic [WORD_W-1:0]     st_data_i,
  output logic                  wt_valid_o,
  output logic [WA_W-1:0]       wt_addr_o,
  output logic [WORD_BYTES-1:0] wt_be_o,
  output logic [WORD_W-1:0]     wt_data_o,
  output logic                  refill_req_o,
  output logic [LA_W-1:0]       refill_addr_o,
  input  logic                  refill_valid_i,
  input  logic [LINE_W-1:0]     refill_data_i,
  input  logic                  inval_valid_i,
  input  logic [LA_W-1:0]       inval_addr_i
);
  logic [NUM_LD-1:0]                ld_vld, ld_hit, ld_miss;
  logic [NUM_LD-1:0][WA_W-1:0]      ld_wa;
  logic [NUM_LD-1:0][LA_W-1:0]      ld_line;
  logic [NUM_LD-1:0][WORD_W-1:0]    ld_dat;
  logic [RD_PORTS-1:0][IDX_W-1:0]   rd_idx;
  logic [RD_PORTS-1:0]              rd_vld;
  logic [RD_PORTS-1:0][TAG_W-1:0]   rd_tag;
  logic [RD_PORTS-1:0][LINE_W-1:0]  rd_line;

  logic              busy, fill_we;
  logic [LA_W-1:0]   pend_line;
  logic [LINE_W-1:0] st_wr_line, fill_line;
  logic              st_hit, st_merge;
  logic [TAG_W-1:0]  st_tag;
  logic [LA_W-1:0]   st_line_a;

  assign ld_vld   = {ld1_valid_i, ld0_valid_i};
  assign ld_wa[0] = ld0_addr_i;
  assign ld_wa[1] = ld1_addr_i;

  for (genvar p = 0; p < NUM_LD; p++) begin : g_ld
    assign ld_line[p] = ld_wa[p][WA_W-1:WSEL_W];
    assign rd_idx[p]  = ld_wa[p][WSEL_W +: IDX_W];

    dcache_lookup #(
      .TAG_W (TAG_W),
      .LINE_W(LINE_W),
      .WORD_W(WORD_W),
      .WSEL_W(WSEL_W)
    ) u_lookup (
      .req_i     (ld_vld[p]),
      .tag_i     (ld_wa[p][WA_W-1 -: TAG_W]),
      .wsel_i    (ld_wa[p][WSEL_W-1:0]),
      .blk_i     (busy && (ld_line[p] == pend_line)),
      .arr_vld_i (rd_vld[p]),
      .arr_tag_i (rd_tag[p]),
      .arr_line_i(rd_line[p]),
      .hit_o     (ld_hit[p]),
      .miss_o    (ld_miss[p]),
      .data_o    (ld_dat[p])
    );
  end

  assign ld0_hit_o  = ld_hit[0];
  assign ld1_hit_o  = ld_hit[1];
  assign ld0_data_o = ld_dat[0];
  assign ld1_data_o = ld_dat[1];

  // store path: third read port supplies the line for the byte merge
  assign rd_idx[ST_RD] = st_addr_i[WSEL_W +: IDX_W];
  assign st_tag        = st_addr_i[WA_W-1 -: TAG_W];
  assign st_line_a     = st_addr_i[WA_W-1:WSEL_W];
  assign st_hit        = st_valid_i && rd_vld[ST_RD] && (rd_tag[ST_RD] == st_tag);
  assign st_merge      = st_valid_i && (st_line_a == pend_line);

  assign wt_valid_o = st_valid_i;
  assign wt_addr_o  = st_addr_i;
  assign wt_be_o    = st_be_i;
  assign wt_data_o  = st_data_i;

  dcache_byte_merge #(
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES),
    .WSEL_W    (WSEL_W)
  ) u_st_merge (
    .base_i(rd_line[ST_RD]),
    .en_i  (1'b1),
    .wsel_i(st_addr_i[WSEL_W-1:0]),
    .be_i  (st_be_i),
    .data_i(st_data_i),
    .line_o(st_wr_line)
  );

  dcache_byte_merge #(
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES),
    .WSEL_W    (WSEL_W)
  ) u_fill_merge (
    .base_i(refill_data_i),
    .en_i  (st_merge),
    .wsel_i(st_addr_i[WSEL_W-1:0]),
    .be_i  (st_be_i),
    .data_i(st_data_i),
    .line_o(fill_line)
  );

  dcache_refill_ctrl #(
    .LA_W(LA_W)
  ) u_refill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .miss_i     (ld_miss),
    .miss_line_i(ld_line),
    .done_i     (refill_valid_i),
    .busy_o     (busy),
    .line_o     (pend_line),
    .fill_o     (fill_we)
  );

  assign refill_req_o  = busy;
  assign refill_addr_o = pend_line;

  dcache_array #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W),
    .NRD   (RD_PORTS)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_vld_o   (rd_vld),
    .rd_tag_o   (rd_tag),
    .rd_line_o  (rd_line),
    .st_we_i    (st_hit),
    .st_idx_i   (rd_idx[ST_RD]),
    .st_line_i  (st_wr_line),
    .fill_we_i  (fill_we),
    .fill_idx_i (pend_line[IDX_W-1:0]),
    .fill_tag_i (pend_line[LA_W-1 -: TAG_W]),
    .fill_line_i(fill_line),
    .inv_en_i   (inval_valid_i),
    .inv_idx_i  (inval_addr_i[IDX_W-1:0]),
    .inv_tag_i  (inval_addr_i[LA_W-1 -: TAG_W])
  );
endmodule

// File: rtl/dcache_dual_rd_chk.sv
module dcache_dual_rd_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int BSEL_W = $clog2(WORD_BYTES),
  localparam int WSEL_W = OFF_W - BSEL_W,
  localparam int WA_W   = ADDR_W - BSEL_W,
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ld0_valid_i,
  input logic [WA_W-1:0] ld0_addr_i,
  input logic            ld0_hit_o,
  input logic            refill_req_o,
  input logic [LA_W-1:0] refill_addr_o,
  input logic            refill_valid_i,
  input logic            inval_valid_i,
  input logic [LA_W-1:0] inval_addr_i
);
  logic [LA_W-1:0] ld0_line;
  assign ld0_line = ld0_addr_i[WA_W-1:WSEL_W];

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o && !refill_valid_i |=> refill_req_o && $stable(refill_addr_o)); // R6

  AST_FILL_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o && refill_valid_i && !(inval_valid_i && inval_addr_i == refill_addr_o)
    |=> !(ld0_valid_i && ld0_line == $past(refill_addr_o)) || ld0_hit_o); // R6

  AST_PORT0_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refill_req_o && ld0_valid_i && !ld0_hit_o
    |=> refill_req_o && refill_addr_o == $past(ld0_line)); // R7

  AST_PEND_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o && ld0_valid_i && ld0_line == refill_addr_o |-> !ld0_hit_o); // R8

  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_valid_i |=> !(ld0_valid_i && ld0_line == $past(inval_addr_i) && ld0_hit_o)); // R9

  AST_INVAL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o && refill_valid_i && inval_valid_i && inval_addr_i == refill_addr_o
    |=> !(ld0_valid_i && ld0_line == $past(refill_addr_o) && ld0_hit_o)); // R10
endmodule

bind dcache_dual_rd dcache_dual_rd_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ld0_valid_i   (ld0_valid_i),
  .ld0_addr_i    (ld0_addr_i),
  .ld0_hit_o     (ld0_hit_o),
  .refill_req_o  (refill_req_o),
  .refill_addr_o (refill_addr_o),
  .refill_valid_i(refill_valid_i),
  .inval_valid_i (inval_valid_i),
  .inval_addr_i  (inval_addr_i)
);

// File: tb/dcache_dual_rd_bench.sv
module dcache_dual_rd_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WA_W = 29;
  localparam int LA_W = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic            ld0_valid = 0, ld1_valid = 0, st_valid = 0;
  logic [WA_W-1:0] ld0_addr = '0, ld1_addr = '0, st_addr = '0;
  logic [7:0]      st_be = '0;
  logic [63:0]     st_data = '0;
  logic            ld0_hit, ld1_hit, wt_valid;
  logic [63:0]     ld0_data, ld1_data, wt_data;
  logic [WA_W-1:0] wt_addr;
  logic [7:0]      wt_be;
  logic            refill_req;
  logic [LA_W-1:0] refill_addr;
  logic            refill_valid = 0;
  logic [255:0]    refill_data = '0;
  logic            inval_valid = 0;
  logic [LA_W-1:0] inval_addr = '0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_dual_rd u_dcache_dual_rd (
    .clk_i(clk), .rst_ni(rst_n),
    .ld0_valid_i(ld0_valid), .ld0_addr_i(ld0_addr), .ld0_hit_o(ld0_hit), .ld0_data_o(ld0_data),
    .ld1_valid_i(ld1_valid), .ld1_addr_i(ld1_addr), .ld1_hit_o(ld1_hit), .ld1_data_o(ld1_data),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_be_i(st_be), .st_data_i(st_data),
    .wt_valid_o(wt_valid), .wt_addr_o(wt_addr), .wt_be_o(wt_be), .wt_data_o(wt_data),
    .refill_req_o(refill_req), .refill_addr_o(refill_addr),
    .refill_valid_i(refill_valid), .refill_data_i(refill_data),
    .inval_valid_i(inval_valid), .inval_addr_i(inval_addr)
  );

  function automatic logic [WA_W-1:0] wa(input logic [31:0] a);
    return a[31:3];
  endfunction

  function automatic logic [LA_W-1:0] la(input logic [31:0] a);
    return a[31:5];
  endfunction

  function automatic logic [255:0] pat(input logic [LA_W-1:0] l);
    logic [255:0] r;
    for (int k = 0; k < 32; k++) begin
      logic [7:0] kb;
      kb = 8'(k);
      r[k*8 +: 8] = l[7:0] ^ (kb * 8'd17) ^ 8'h5A;
    end
    return r;
  endfunction

  function automatic logic [63:0] word_of(input logic [255:0] line, input logic [31:0] a);
    return line[a[4:3]*64 +: 64];
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    #1;
  endtask

  // wait for a request, check its address, deliver the pattern line
  task automatic serve(input logic [LA_W-1:0] l, input string r);
    for (int i = 0; i < 10 && !refill_req; i++) cyc();
    chk(r, 64'(refill_req), 64'd1);
    chk(r, 64'(refill_addr), 64'(l));
    refill_valid = 1'b1;
    refill_data  = pat(l);
    @(negedge clk);
    refill_valid = 1'b0;
    #1;
  endtask

  task automatic fill0(input logic [31:0] a);
    @(negedge clk);
    ld0_valid = 1'b1;
    ld0_addr  = wa(a);
    #1 chk("R6 miss before fill", 64'(ld0_hit), 64'd0);
    cyc();
    chk("R6 request raised", 64'(refill_req), 64'd1);
    chk("R6 request address", 64'(refill_addr), 64'(la(a)));
    serve(la(a), "R6 serve");
    chk("R6 hit after fill", 64'(ld0_hit), 64'd1);
    chk("R1 word select", ld0_data, word_of(pat(la(a)), a));
    ld0_valid = 1'b0;
  endtask

  localparam logic [31:0] A  = 32'h0000_1000;
  localparam logic [31:0] B  = 32'h0000_2040;
  localparam logic [31:0] BX = 32'h0000_4040;
  localparam logic [31:0] C  = 32'h0000_0300;
  localparam logic [31:0] D  = 32'h0000_0400;
  localparam logic [31:0] E  = 32'h0000_0520;
  localparam logic [31:0] F  = 32'h0000_0640;
  localparam logic [31:0] G  = 32'h0000_0760;
  localparam logic [31:0] H  = 32'h0000_0880;

  task automatic t_reset;
    #1;
    chk("R12 no request in reset", 64'(refill_req), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R12 no request after reset", 64'(refill_req), 64'd0);
    chk("R12 no write-through idle", 64'(wt_valid), 64'd0);
  endtask

  task automatic t_dual_hit;
    fill0(A);
    fill0(B);
    @(negedge clk);
    ld0_valid = 1; ld0_addr = wa(A + 8);
    ld1_valid = 1; ld1_addr = wa(B + 24);
    #1;
    chk("R2 port0 hit", 64'(ld0_hit), 64'd1);
    chk("R2 port1 hit", 64'(ld1_hit), 64'd1);
    chk("R2 port0 data", ld0_data, word_of(pat(la(A)), A + 8));
    chk("R2 port1 data", ld1_data, word_of(pat(la(B)), B + 24));
    @(negedge clk);
    ld1_addr = wa(A + 24);
    #1;
    chk("R2 same line port1", ld1_data, word_of(pat(la(A)), A + 24));
    chk("R2 same line port0", ld0_data, word_of(pat(la(A)), A + 8));
    ld0_valid = 0; ld1_valid = 0;
  endtask

  task automatic t_store_hit;
    logic [63:0] old_w, nw;
    old_w = word_of(pat(la(A)), A + 16);
    nw    = 64'h1122_3344_5566_7788;
    @(negedge clk);
    st_valid = 1; st_addr = wa(A + 16); st_be = 8'h0F; st_data = nw;
    ld0_valid = 1; ld0_addr = wa(A + 16);
    #1;
    chk("R3 wt valid", 64'(wt_valid), 64'd1);
    chk("R3 wt addr", 64'(wt_addr), 64'(wa(A + 16)));
    chk("R3 wt be", 64'(wt_be), 64'h0F);
    chk("R3 wt data", wt_data, nw);
    chk("R4 old data in store cycle", ld0_data, old_w);
    @(negedge clk);
    st_valid = 0;
    #1;
    chk("R4 enabled bytes only", ld0_data, {old_w[63:32], nw[31:0]});
    ld0_valid = 0;
  endtask

  task automatic t_store_miss;
    @(negedge clk);
    st_valid = 1; st_addr = wa(C); st_be = 8'hFF; st_data = 64'hDEAD_BEEF_0BAD_F00D;
    #1;
    chk("R3 wt on miss", 64'(wt_valid), 64'd1);
    chk("R3 wt addr on miss", 64'(wt_addr), 64'(wa(C)));
    @(negedge clk);
    st_valid = 0;
    #1 chk("R5 no refill on store miss", 64'(refill_req), 64'd0);
    cyc();
    chk("R5 still no refill", 64'(refill_req), 64'd0);
    fill0(C);
    chk("R5 line came from refill", ld0_data, word_of(pat(la(C)), C));
  endtask

  task automatic t_both_miss;
    @(negedge clk);
    ld0_valid = 1; ld0_addr = wa(D);
    ld1_valid = 1; ld1_addr = wa(E + 8);
    #1;
    chk("R7 port0 miss", 64'(ld0_hit), 64'd0);
    chk("R7 port1 miss", 64'(ld1_hit), 64'd0);
    cyc();
    chk("R7 port0 line first", 64'(refill_addr), 64'(la(D)));
    serve(la(D), "R7 serve first");
    chk("R7 port0 hit", 64'(ld0_hit), 64'd1);
    chk("R7 port1 still miss", 64'(ld1_hit), 64'd0);
    cyc();
    chk("R7 port1 line second", 64'(refill_addr), 64'(la(E)));
    serve(la(E), "R7 serve second");
    chk("R7 port1 hit", 64'(ld1_hit), 64'd1);
    chk("R7 port1 data", ld1_data, word_of(pat(la(E)), E + 8));
    ld0_valid = 0; ld1_valid = 0;
  endtask

  task automatic t_pending;
    @(negedge clk);
    ld0_valid = 1; ld0_addr = wa(F);
    @(negedge clk);
    ld1_valid = 1; ld1_addr = wa(F + 16);
    #1;
    chk("R8 request out", 64'(refill_req), 64'd1);
    chk("R8 port1 waits", 64'(ld1_hit), 64'd0);
    cyc();
    chk("R8 port1 still waits", 64'(ld1_hit), 64'd0);
    chk("R8 single request", 64'(refill_addr), 64'(la(F)));
    serve(la(F), "R8 serve");
    chk("R8 port1 hit after fill", 64'(ld1_hit), 64'd1);
    chk("R8 port1 data", ld1_data, word_of(pat(la(F)), F + 16));
    ld0_valid = 0; ld1_valid = 0;
  endtask

  task automatic t_inval;
    @(negedge clk);
    inval_valid = 1; inval_addr = la(BX);
    @(negedge clk);
    inval_valid = 0;
    ld0_valid = 1; ld0_addr = wa(B);
    #1 chk("R9 other tag kept", 64'(ld0_hit), 64'd1);
    @(negedge clk);
    ld0_valid = 0;
    inval_valid = 1; inval_addr = la(A);
    @(negedge clk);
    inval_valid = 0;
    ld0_valid = 1; ld0_addr = wa(A);
    #1 chk("R9 matching line cleared", 64'(ld0_hit), 64'd0);
    serve(la(A), "R9 refetch");
    chk("R9 hit after refetch", 64'(ld0_hit), 64'd1);
    ld0_valid = 0;
  endtask

  task automatic t_inval_race;
    @(negedge clk);
    ld0_valid = 1; ld0_addr = wa(G);
    cyc();
    chk("R10 request out", 64'(refill_addr), 64'(la(G)));
    refill_valid = 1; refill_data = pat(la(G));
    inval_valid  = 1; inval_addr  = la(G);
    @(negedge clk);
    refill_valid = 0; inval_valid = 0;
    #1 chk("R10 invalidate wins", 64'(ld0_hit), 64'd0);
    cyc();
    chk("R10 re-request", 64'(refill_addr), 64'(la(G)));
    serve(la(G), "R10 serve again");
    chk("R10 hit after second fill", 64'(ld0_hit), 64'd1);
    ld0_valid = 0;
  endtask

  task automatic t_fill_store_merge;
    logic [63:0] sw, base;
    sw   = 64'hCAFE_F00D_1234_5678;
    base = word_of(pat(la(H)), H + 8);
    @(negedge clk);
    ld0_valid = 1; ld0_addr = wa(H + 8);
    cyc();
    chk("R11 request out", 64'(refill_addr), 64'(la(H)));
    refill_valid = 1; refill_data = pat(la(H));
    st_valid = 1; st_addr = wa(H + 8); st_be = 8'hF0; st_data = sw;
    @(negedge clk);
    refill_valid = 0; st_valid = 0;
    #1;
    chk("R11 hit after merged fill", 64'(ld0_hit), 64'd1);
    chk("R11 merged word", ld0_data, {sw[63:32], base[31:0]});
    ld0_valid = 0;
  endtask

  initial begin
    t_reset();
    t_dual_hit();
    t_store_hit();
    t_store_miss();
    t_both_miss();
    t_pending();
    t_inval();
    t_inval_race();
    t_fill_store_merge();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule